// File: doc/BRIEF.md
# Multi-Mode Timer Channel Start Sequencer

This block is one 16-bit timer channel whose behaviour between a software start write and its first counting step depends on one of five operating modes. Each mode decides whether the count register is loaded at the start write or at the first count-clock enable that follows it. It also decides whether the load value is the data word or zero, whether the channel counts down or up, and whether the channel must first wait for an edge on the external timer input. A prescaled count-clock enable paces counting. The prescaler that makes this enable is outside the block.

The external timer input passes through a two-flop synchronizer and an edge register. A polarity input chooses which edge counts as the valid edge. The channel produces a count value, a capture value, a one-cycle interrupt pulse and a running flag. Software pulses `start` to arm the channel and `stop` to halt it. The mode and data inputs are expected to stay constant while the channel runs.

Top module: `timer_chan_start`

## Requirements
- R1: After reset, `count` and `capture` are 0, `irq` is 0 and `running` is 0.
- R2: While `running` is 0, `count` and `capture` do not change, whatever `cnt_en` and `tin` do, until a start is accepted.
- R3: A `start` pulse sets `running` at the next clock edge. A `stop` pulse clears it. When both are high in the same cycle, `stop` wins. A stop freezes `count` in the same edge, even if `cnt_en` is high.
- R4: Interval mode (mode 3'd0). The start write leaves `count` unchanged. The first `cnt_en` after the start copies `data` into `count`. Each later `cnt_en` decrements `count` by one.
- R5: Interval mode. A `cnt_en` that arrives while `count` is 0 reloads `data` and raises `irq` for one cycle.
- R6: Event mode (mode 3'd1). The start write itself copies `data` into `count`. After that, each valid `tin` edge decrements `count`. A valid edge that arrives at 0 reloads `data` and pulses `irq`. In this mode `cnt_en` has no effect.
- R7: Capture mode (mode 3'd2). The start write leaves `count` unchanged. The first `cnt_en` loads 0. Each later `cnt_en` increments `count`.
- R8: Capture mode. A valid `tin` edge copies `count` into `capture`, pulses `irq` and clears `count` to 0.
- R9: One-shot countdown (mode 3'd3). A start puts the channel into a waiting state, in which `cnt_en` has no effect. A valid edge ends the wait. The next `cnt_en` loads `data`, and later ones count down. A `cnt_en` at 0 pulses `irq` and returns the channel to the waiting state, with `count` held at 0.
- R10: One-shot high-interval measurement (mode 3'd4). A start puts the channel into the waiting state. A valid edge ends the wait. The next `cnt_en` loads 0, and later ones count up. The opposite edge copies `count` into `capture`, pulses `irq` and returns the channel to the waiting state.
- R11: `edge_pol` = 1 selects the rising edge of `tin` as the valid edge and 0 selects the falling edge. A `tin` change that is stable before clock edge k takes effect at edge k+2.
- R12: `capture` changes only in a cycle in which `irq` is also asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 3 | Operating mode, codes 0 to 4 |
| edge_pol | input | 1 | Valid edge of `tin`: 1 rising, 0 falling |
| data | input | 16 | Reload value |
| cnt_en | input | 1 | Prescaled count-clock enable |
| tin | input | 1 | External timer input, asynchronous |
| start | input | 1 | Software start strobe |
| stop | input | 1 | Software stop strobe |
| count | output | 16 | Count register |
| capture | output | 16 | Captured count |
| irq | output | 1 | One-cycle interrupt pulse |
| running | output | 1 | Channel enable status |

## Verification
A start, stop or `cnt_en` pulse applied before an edge shows its effect on `count`, `running` and `irq` right after that same edge. A change on `tin` acts three edges after it is applied: two synchronizer stages and the edge register come first. The bench therefore drives every input 1 ns after a rising edge and samples 1 ns after the edge at which the result is due. It counts those edges explicitly, and it checks that nothing has happened one edge early on the `tin` path. For each mode, the expected counts, captures and interrupt positions come from the data value and the pulse index by modular arithmetic.

// File: rtl/timer_chan_start.sv
`timescale 1ns/1ps
module timer_chan_start #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   mode,
  input  logic         edge_pol,
  input  logic [W-1:0] data,
  input  logic         cnt_en,
  input  logic         tin,
  input  logic         start,
  input  logic         stop,
  output logic [W-1:0] count,
  output logic [W-1:0] capture,
  output logic         irq,
  output logic         running
);
  localparam logic [2:0] M_INTV = 3'd0, M_EVNT = 3'd1, M_CAPT = 3'd2,
                         M_ONES = 3'd3, M_HIGH = 3'd4;

  logic [2:0] sync_q;
  logic       load_pend, wait_trig;

  wire rise     = sync_q[1] & ~sync_q[2];
  wire fall     = ~sync_q[1] & sync_q[2];
  wire edge_on  = edge_pol ? rise : fall;
  wire edge_off = edge_pol ? fall : rise;
  wire zero_ld  = (mode == M_CAPT) || (mode == M_HIGH);
  wire at_zero  = (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= '0;
      count     <= '0;
      capture   <= '0;
      irq       <= 1'b0;
      running   <= 1'b0;
      load_pend <= 1'b0;
      wait_trig <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], tin};
      irq    <= 1'b0;
      if (stop) begin
        running   <= 1'b0;
        load_pend <= 1'b0;
        wait_trig <= 1'b0;
      end else if (start) begin
        running <= 1'b1;
        case (mode)
          M_EVNT: begin
            count     <= data;
            load_pend <= 1'b0;
            wait_trig <= 1'b0;
          end
          M_ONES, M_HIGH: begin
            load_pend <= 1'b0;
            wait_trig <= 1'b1;
          end
          default: begin
            load_pend <= 1'b1;
            wait_trig <= 1'b0;
          end
        endcase
      end else if (running) begin
        if (wait_trig) begin
          if (edge_on) begin
            wait_trig <= 1'b0;
            load_pend <= 1'b1;
          end
        end else if (load_pend) begin
          if (cnt_en) begin
            count     <= zero_ld ? '0 : data;
            load_pend <= 1'b0;
          end
        end else begin
          case (mode)
            M_INTV, M_ONES: if (cnt_en) begin
              if (at_zero) begin
                irq <= 1'b1;
                if (mode == M_INTV) count <= data;
                else wait_trig <= 1'b1;
              end else count <= count - 1'b1;
            end
            M_EVNT: if (edge_on) begin
              if (at_zero) begin
                irq   <= 1'b1;
                count <= data;
              end else count <= count - 1'b1;
            end
            M_CAPT: begin
              if (edge_on) begin
                capture <= count;
                irq     <= 1'b1;
                count   <= '0;
              end else if (cnt_en) count <= count + 1'b1;
            end
            M_HIGH: begin
              if (edge_off) begin
                capture   <= count;
                irq       <= 1'b1;
                wait_trig <= 1'b1;
              end else if (cnt_en) count <= count + 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  p_hold_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start) |=> ($stable(count) && $stable(capture)));
  p_stop_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !running);
  p_start_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !stop) |=> running);
  p_defer_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !stop && mode == M_INTV) |=> $stable(count));
  p_irq_needs_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(running));
  p_evt_immediate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !stop && mode == M_EVNT) |=> (count == $past(data)));
  p_wait_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && wait_trig && !start && !stop) |=> $stable(count));
  p_capture_irq_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(capture) |-> irq);
endmodule

// File: tb/timer_chan_start_bench.sv
`timescale 1ns/1ps
module timer_chan_start_bench;
  logic clk = 0, rst_n = 0;
  logic [2:0] mode = 0;
  logic edge_pol = 1, cnt_en = 0, tin = 0, start = 0, stop = 0;
  logic [15:0] data = 0;
  logic [15:0] count, capture;
  logic irq, running;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] prior;

  timer_chan_start u_timer_chan_start (.*);

  always #4 clk = ~clk;

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_cnt();
    cnt_en = 1; tick(); cnt_en = 0;
  endtask

  task automatic do_start();
    start = 1; tick(); start = 0;
  endtask

  task automatic do_stop();
    stop = 1; tick(); stop = 0;
  endtask

  task automatic edge_to(logic v);
    tin = v; tick(); tick(); tick();
  endtask

  initial begin
    #1600000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    chk("R1 count", count, 0); chk("R1 capture", capture, 0);
    chk("R1 irq", irq, 0); chk("R1 running", running, 0);
    rst_n = 1; tick();

    data = 16'd9;
    for (int i = 0; i < 4; i++) begin pulse_cnt(); edge_to(~tin); end
    chk("R2 count held", count, 0); chk("R2 capture held", capture, 0);
    chk("R2 running", running, 0);
    edge_to(0);

    mode = 3'd0;
    for (int d = 0; d <= 4; d++) begin
      do_stop(); data = d[15:0]; prior = count;
      do_start();
      chk("R3 running", running, 1); chk("R4 deferred", count, prior);
      for (int n = 1; n <= 2 * (d + 1) + 1; n++) begin
        pulse_cnt();
        chk("R4 count", count, n == 1 ? d : d - ((n - 1) % (d + 1)));
        chk("R5 irq", irq, (n > 1 && (n - 1) % (d + 1) == 0) ? 1 : 0);
        if (n % 2 == 0) begin
          tick();
          chk("R4 idle hold", count, n == 1 ? d : d - ((n - 1) % (d + 1)));
          chk("R5 irq low", irq, 0);
        end
      end
    end

    do_stop(); data = 16'd5; do_start(); pulse_cnt(); pulse_cnt();
    chk("R4 before stop", count, 4);
    stop = 1; cnt_en = 1; tick(); stop = 0; cnt_en = 0;
    chk("R3 stop clears", running, 0); chk("R3 stop freezes", count, 4);
    pulse_cnt(); chk("R3 stopped hold", count, 4);
    start = 1; stop = 1; tick(); start = 0; stop = 0;
    chk("R3 stop wins", running, 0);

    mode = 3'd1;
    for (int p = 0; p <= 1; p++) begin
      for (int d = 1; d <= 3; d++) begin
        do_stop(); edge_pol = p[0]; edge_to(~edge_pol);
        data = d[15:0]; do_start();
        chk("R6 immediate load", count, d);
        pulse_cnt(); pulse_cnt();
        chk("R6 cnt_en ignored", count, d);
        for (int k = 1; k <= d + 1; k++) begin
          edge_to(edge_pol);
          chk("R6 R11 edge count", count, k <= d ? d - k : d);
          chk("R6 irq", irq, k == d + 1 ? 1 : 0);
          edge_to(~edge_pol);
          chk("R11 wrong edge", count, k <= d ? d - k : d);
        end
      end
    end

    mode = 3'd2; edge_pol = 1;
    do_stop(); edge_to(0);
    for (int k = 1; k <= 5; k++) begin
      do_stop(); prior = count; do_start();
      chk("R7 deferred", count, prior);
      for (int j = 1; j <= k; j++) begin
        pulse_cnt(); chk("R7 count up", count, j - 1);
      end
      tin = 1; tick(); tick();
      chk("R11 not early", irq, 0);
      tick();
      chk("R8 capture", capture, k - 1); chk("R8 irq", irq, 1);
      chk("R8 cleared", count, 0);
      edge_to(0);
      chk("R12 capture stable", capture, k - 1); chk("R8 irq once", irq, 0);
      pulse_cnt(); chk("R8 restart", count, 1);
    end

    mode = 3'd3; edge_pol = 1;
    for (int d = 0; d <= 3; d++) begin
      do_stop(); edge_to(0); data = d[15:0]; prior = count;
      do_start();
      pulse_cnt(); pulse_cnt();
      chk("R9 waiting", count, prior);
      for (int r = 0; r < 2; r++) begin
        edge_to(1); chk("R9 trigger no load", count, r == 0 ? prior : 0);
        edge_to(0);
        pulse_cnt(); chk("R9 load", count, d);
        for (int j = 1; j <= d; j++) begin
          pulse_cnt(); chk("R9 down", count, d - j);
        end
        pulse_cnt(); chk("R9 irq", irq, 1); chk("R9 end", count, 0);
        pulse_cnt(); chk("R9 rewait", count, 0); chk("R9 irq low", irq, 0);
      end
    end

    mode = 3'd4; edge_pol = 1;
    for (int k = 1; k <= 4; k++) begin
      do_stop(); edge_to(0); prior = count; do_start();
      pulse_cnt(); chk("R10 waiting", count, prior);
      edge_to(1);
      for (int j = 1; j <= k; j++) begin
        pulse_cnt(); chk("R10 count up", count, j - 1);
      end
      edge_to(0);
      chk("R10 capture", capture, k - 1); chk("R10 irq", irq, 1);
      pulse_cnt(); chk("R10 rewait", count, k - 1);
      edge_to(1); pulse_cnt(); chk("R10 rearm", count, 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule